// File: doc/BRIEF.md
# Delay-Slot Writeback Scheduler

This block keeps a record of the instructions issued to one group of functional units. It is a scoreboard and does no arithmetic. Every issued instruction carries an operation class. The class sets two independent figures: how many delay slots pass before the result may be read, and how many cycles the instruction holds its functional unit. In the issue cycle the block compares both source registers with the results still in flight. It raises `hazard` if a read would return a stale value. It raises `unitBusy` if the chosen unit is still held by an earlier multi-cycle operation. When a pending result becomes visible, the block marks the destination register on a per-register writeback vector. A branch pulses `branchTaken` instead.

The block only reports. An instruction is recorded even when one of the flags is raised. Whatever sits upstream decides whether to stall or reissue. There are 32 registers. Numbers 0 to 15 form the first file and 16 to 31 the second.

Top module: `writeback_scheduler`

## Requirements
- R1: Class code 0 (single-cycle ALU) has zero delay slots. Its destination bit in `wbVec` is set in the cycle after issue, and a read of that register in that cycle raises no `hazard`.
- R2: Class code 1 (16-bit multiply) has one delay slot. A read of its destination in the cycle after issue raises `hazard`, and the `wbVec` bit is set in the second cycle after issue.
- R3: Class code 2 (load) has four delay slots. Reads of its destination in cycles 1 to 4 after issue raise `hazard`, and the `wbVec` bit is set in cycle 5.
- R4: Class code 3 (branch) has five delay slots. It pulses `branchTaken` in cycle 6 after issue and never sets a `wbVec` bit.
- R5: Class code 5 (double-precision multiply) has nine delay slots, and its `wbVec` bit is set in cycle 10 after issue.
- R6: Class code 5 holds its unit for four cycles. An issue to the same `issueUnit` value in cycles 1 to 3 after it raises `unitBusy`. An issue to any other unit does not.
- R7: Classes 0 to 4 hold their unit for one cycle only. An issue to the same unit in the next cycle raises no `unitBusy`, even if that unit was held before.
- R8: Class code 4 (store) writes no register and has no delay. It never sets a `wbVec` bit or causes a `hazard`.
- R9: When a newer instruction targets a register that still has a pending result, the newer one wins. The register is written back only once, at the newer instruction's time, and the older result causes no further `hazard`.
- R10: `hazard` checks both `issueSrcA` and `issueSrcB`. Neither `hazard` nor `unitBusy` is raised while `issueValid` is low.
- R11: While and after reset, with nothing issued, `wbVec`, `hazard`, `unitBusy` and `branchTaken` are all zero.
- R12: Class codes 6 and 7 record nothing. They produce no writeback, no branch pulse and no unit hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | An instruction is issued this cycle |
| issueClass | input | 3 | Operation class code |
| issueDst | input | 5 | Destination register number |
| issueSrcA | input | 5 | First source register number |
| issueSrcB | input | 5 | Second source register number |
| issueUnit | input | 3 | Functional unit the instruction is sent to |
| hazard | output | 1 | A source reads a result that is still in its delay slots |
| unitBusy | output | 1 | The selected unit is held by an earlier operation |
| wbVec | output | 32 | One bit per register whose result becomes visible this cycle |
| branchTaken | output | 1 | A branch's delay slots have ended |

## Verification
The properties assume that at most one instruction arrives per cycle and that every issue field is a known value while `issueValid` is high. They also assume that `issueValid` stays low during reset. The stimulus drives every field to a defined value in every cycle, including idle ones. It issues only from tasks that present a single instruction at a time, and it keeps the issue strobe low until reset has been released. Directed sequences then place register and unit collisions at each class's exact boundary cycles, and a long random run mixes all eight class codes.

// File: rtl/wbs_pkg.sv
package wbs_pkg;
  parameter int REG_W  = 5;
  parameter int CNT_W  = 4;
  parameter int UNIT_W = 3;
  parameter int HOLD_W = 2;

  typedef enum logic [2:0] {
    CLS_ALU    = 3'd0,
    CLS_MUL    = 3'd1,
    CLS_LOAD   = 3'd2,
    CLS_BRANCH = 3'd3,
    CLS_STORE  = 3'd4,
    CLS_DPMUL  = 3'd5
  } opClass_e;

  // strobes from issue control to the tracking datapath
  typedef struct packed {
    logic              wrEn;
    logic [REG_W-1:0]  wrReg;
    logic [CNT_W-1:0]  wrDelay;
    logic              unitEn;
    logic [UNIT_W-1:0] unitId;
    logic [HOLD_W-1:0] unitHold;
    logic              brEn;
  } issueStb_t;
endpackage

// File: rtl/wbs_issue_ctrl.sv
module wbs_issue_ctrl
  import wbs_pkg::*;
#(
  parameter int DLY_MUL    = 1,
  parameter int DLY_LOAD   = 4,
  parameter int DLY_DPMUL  = 9,
  parameter int HOLD_DPMUL = 4,
  localparam int NUM_REGS  = 1 << REG_W,
  localparam int NUM_UNITS = 1 << UNIT_W
) (
  input  logic                 issueValid,
  input  logic [2:0]           issueClass,
  input  logic [REG_W-1:0]     issueDst,
  input  logic [REG_W-1:0]     issueSrcA,
  input  logic [REG_W-1:0]     issueSrcB,
  input  logic [UNIT_W-1:0]    issueUnit,
  input  logic [NUM_REGS-1:0]  pendMask,
  input  logic [NUM_UNITS-1:0] busyMask,
  output issueStb_t            stb,
  output logic                 hazard,
  output logic                 unitBusy
);
  logic knownClass;
  logic wrReq;
  logic brReq;
  logic [CNT_W-1:0]  delaySel;
  logic [HOLD_W-1:0] holdSel;

  always_comb begin
    knownClass = 1'b1;
    wrReq      = 1'b0;
    brReq      = 1'b0;
    delaySel   = '0;
    holdSel    = '0;
    case (issueClass)
      CLS_ALU:    wrReq = 1'b1;
      CLS_MUL:    begin wrReq = 1'b1; delaySel = CNT_W'(DLY_MUL); end
      CLS_LOAD:   begin wrReq = 1'b1; delaySel = CNT_W'(DLY_LOAD); end
      CLS_BRANCH: brReq = 1'b1;
      CLS_STORE:  ;
      CLS_DPMUL: begin
        wrReq    = 1'b1;
        delaySel = CNT_W'(DLY_DPMUL);
        holdSel  = HOLD_W'(HOLD_DPMUL - 1);
      end
      default:    knownClass = 1'b0;
    endcase
  end

  always_comb begin
    stb.wrEn     = issueValid && wrReq;
    stb.wrReg    = issueDst;
    stb.wrDelay  = delaySel;
    stb.unitEn   = issueValid && knownClass;
    stb.unitId   = issueUnit;
    stb.unitHold = holdSel;
    stb.brEn     = issueValid && brReq;
  end

  assign hazard   = issueValid && (pendMask[issueSrcA] || pendMask[issueSrcB]);
  assign unitBusy = issueValid && busyMask[issueUnit];
endmodule

// File: rtl/wbs_track_dp.sv
module wbs_track_dp
  import wbs_pkg::*;
#(
  parameter int DLY_BRANCH = 5,
  localparam int NUM_REGS  = 1 << REG_W,
  localparam int NUM_UNITS = 1 << UNIT_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  issueStb_t            stb,
  output logic [NUM_REGS-1:0]  pendMask,
  output logic [NUM_REGS-1:0]  wbVec,
  output logic [NUM_UNITS-1:0] busyMask,
  output logic                 branchTaken
);
  // per-register countdown: a newer write simply reloads it
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic             live;
    logic [CNT_W-1:0] remain;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        live   <= 1'b0;
        remain <= '0;
      end else if (stb.wrEn && stb.wrReg == REG_W'(r)) begin
        live   <= 1'b1;
        remain <= stb.wrDelay;
      end else if (live) begin
        if (remain == '0) live <= 1'b0;
        else              remain <= remain - 1'b1;
      end
    end
    assign pendMask[r] = live && (remain != '0);
    assign wbVec[r]    = live && (remain == '0);
  end

  // per-unit hold counter
  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic [HOLD_W-1:0] hold;
    always_ff @(posedge clk) begin
      if (!rstN)                                       hold <= '0;
      else if (stb.unitEn && stb.unitId == UNIT_W'(u)) hold <= stb.unitHold;
      else if (hold != '0)                             hold <= hold - 1'b1;
    end
    assign busyMask[u] = (hold != '0);
  end

  // branch delay line, one bit per outstanding slot
  logic [DLY_BRANCH:0] brLine;
  always_ff @(posedge clk) begin
    if (!rstN) brLine <= '0;
    else       brLine <= {stb.brEn, brLine[DLY_BRANCH:1]};
  end
  assign branchTaken = brLine[0];
endmodule

// File: rtl/writeback_scheduler.sv
module writeback_scheduler
  import wbs_pkg::*;
#(
  parameter int DLY_MUL    = 1,
  parameter int DLY_LOAD   = 4,
  parameter int DLY_BRANCH = 5,
  parameter int DLY_DPMUL  = 9,
  parameter int HOLD_DPMUL = 4,
  localparam int NUM_REGS  = 1 << REG_W,
  localparam int NUM_UNITS = 1 << UNIT_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                issueValid,
  input  logic [2:0]          issueClass,
  input  logic [REG_W-1:0]    issueDst,
  input  logic [REG_W-1:0]    issueSrcA,
  input  logic [REG_W-1:0]    issueSrcB,
  input  logic [UNIT_W-1:0]   issueUnit,
  output logic                hazard,
  output logic                unitBusy,
  output logic [NUM_REGS-1:0] wbVec,
  output logic                branchTaken
);
  issueStb_t            stb;
  logic [NUM_REGS-1:0]  pendMask;
  logic [NUM_UNITS-1:0] busyMask;

  wbs_issue_ctrl #(
    .DLY_MUL(DLY_MUL), .DLY_LOAD(DLY_LOAD),
    .DLY_DPMUL(DLY_DPMUL), .HOLD_DPMUL(HOLD_DPMUL)
  ) u_ctrl (
    .issueValid(issueValid), .issueClass(issueClass), .issueDst(issueDst),
    .issueSrcA(issueSrcA), .issueSrcB(issueSrcB), .issueUnit(issueUnit),
    .pendMask(pendMask), .busyMask(busyMask),
    .stb(stb), .hazard(hazard), .unitBusy(unitBusy)
  );

  wbs_track_dp #(.DLY_BRANCH(DLY_BRANCH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .pendMask(pendMask), .wbVec(wbVec),
    .busyMask(busyMask), .branchTaken(branchTaken)
  );
endmodule

// File: rtl/wbs_checker.sv
module wbs_checker
  import wbs_pkg::*;
#(
  localparam int NUM_REGS = 1 << REG_W
) (
  input logic                clk,
  input logic                rstN,
  input logic                issueValid,
  input logic [2:0]          issueClass,
  input logic [REG_W-1:0]    issueDst,
  input logic [REG_W-1:0]    issueSrcA,
  input logic [UNIT_W-1:0]   issueUnit,
  input logic                hazard,
  input logic                unitBusy,
  input logic [NUM_REGS-1:0] wbVec
);
  AST_ALU_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueClass == 3'd0) |=> wbVec[$past(issueDst)]); // R1

  AST_MUL_SLOT_STALE: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueClass == 3'd1) |=>
      (!(issueValid && issueSrcA == $past(issueDst)) || hazard)); // R2

  AST_LOAD_SLOT_STALE: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueClass == 3'd2) |=>
      (!(issueValid && issueSrcA == $past(issueDst)) || hazard)); // R3

  AST_DP_UNIT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueClass == 3'd5) |=>
      (!(issueValid && issueUnit == $past(issueUnit)) || unitBusy)); // R6

  AST_SHORT_HOLD_FREE: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueClass <= 3'd4) |=>
      (!(issueValid && issueUnit == $past(issueUnit)) || !unitBusy)); // R7
endmodule

bind writeback_scheduler wbs_checker u_chk (
  .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueClass(issueClass),
  .issueDst(issueDst), .issueSrcA(issueSrcA), .issueUnit(issueUnit),
  .hazard(hazard), .unitBusy(unitBusy), .wbVec(wbVec)
);

// File: tb/writeback_scheduler_tb.sv
module writeback_scheduler_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issueValid = 1'b0;
  logic [2:0]  issueClass = '0;
  logic [4:0]  issueDst = '0, issueSrcA = '0, issueSrcB = '0;
  logic [2:0]  issueUnit = '0;
  logic        hazard, unitBusy, branchTaken;
  logic [31:0] wbVec;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  string curReq = "R11";
  int regDue[32];
  int unitFree[8];
  int brDue[$];

  always #4 clk = ~clk;

  writeback_scheduler u_dut (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueClass(issueClass),
    .issueDst(issueDst), .issueSrcA(issueSrcA), .issueSrcB(issueSrcB),
    .issueUnit(issueUnit), .hazard(hazard), .unitBusy(unitBusy),
    .wbVec(wbVec), .branchTaken(branchTaken)
  );

  // reference model: absolute due cycles per register, unit and branch
  always @(posedge clk) begin
    if (!rstN) begin
      foreach (regDue[i]) regDue[i] = -100;
      foreach (unitFree[i]) unitFree[i] = 0;
      brDue.delete();
      cyc = 0;
    end else begin
      if (issueValid) begin
        case (issueClass)
          3'd0: regDue[issueDst] = cyc + 1;
          3'd1: regDue[issueDst] = cyc + 2;
          3'd2: regDue[issueDst] = cyc + 5;
          3'd3: brDue.push_back(cyc + 6);
          3'd5: regDue[issueDst] = cyc + 10;
          default: ;
        endcase
        if (issueClass <= 3'd5)
          unitFree[issueUnit] = cyc + ((issueClass == 3'd5) ? 4 : 1);
      end
      cyc = cyc + 1;
    end
  end

  task automatic check1(string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s at cycle %0d: actual=%h expected=%h", curReq, what, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic [31:0] expWb;
    logic expHaz, expBusy, expBr;
    expWb = '0;
    for (int r = 0; r < 32; r++) if (rstN && regDue[r] == cyc) expWb[r] = 1'b1;
    expHaz  = rstN && issueValid && (regDue[issueSrcA] > cyc || regDue[issueSrcB] > cyc);
    expBusy = rstN && issueValid && (unitFree[issueUnit] > cyc);
    expBr   = 1'b0;
    foreach (brDue[i]) if (rstN && brDue[i] == cyc) expBr = 1'b1;
    check1("wbVec", wbVec, expWb);
    check1("hazard", 32'(hazard), 32'(expHaz));
    check1("unitBusy", 32'(unitBusy), 32'(expBusy));
    check1("branchTaken", 32'(branchTaken), 32'(expBr));
  end

  task automatic issue(logic v, logic [2:0] c, logic [4:0] d, logic [4:0] a,
                       logic [4:0] b, logic [2:0] u);
    @(posedge clk); #1;
    issueValid = v; issueClass = c; issueDst = d;
    issueSrcA = a; issueSrcB = b; issueUnit = u;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) issue(1'b0, 3'd0, 5'd0, 5'd0, 5'd0, 3'd0);
  endtask

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    foreach (regDue[i]) regDue[i] = -100;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    idle(2);
    curReq = "R1";  issue(1, 3'd0, 5'd3, 5'd1, 5'd2, 3'd0);
                    issue(1, 3'd0, 5'd6, 5'd3, 5'd3, 3'd1); idle(3);
    curReq = "R2";  issue(1, 3'd1, 5'd4, 5'd0, 5'd0, 3'd2);
                    issue(1, 3'd0, 5'd10, 5'd4, 5'd0, 3'd3);
                    issue(1, 3'd0, 5'd11, 5'd4, 5'd0, 3'd3); idle(3);
    curReq = "R3";  issue(1, 3'd2, 5'd20, 5'd0, 5'd0, 3'd4);
    for (int k = 0; k < 6; k++) issue(1, 3'd4, 5'd0, 5'd1, 5'd20, 3'd5);
    idle(2);
    curReq = "R4";  issue(1, 3'd3, 5'd12, 5'd0, 5'd0, 3'd6); idle(8);
    curReq = "R5";  issue(1, 3'd5, 5'd9, 5'd0, 5'd0, 3'd7);
    for (int k = 0; k < 11; k++) issue(1, 3'd4, 5'd0, 5'd9, 5'd0, 3'd1);
    curReq = "R6";  issue(1, 3'd5, 5'd25, 5'd0, 5'd0, 3'd2);
                    issue(1, 3'd0, 5'd26, 5'd0, 5'd0, 3'd2);
                    issue(1, 3'd0, 5'd27, 5'd0, 5'd0, 3'd3);
                    issue(1, 3'd5, 5'd28, 5'd0, 5'd0, 3'd2);
                    issue(1, 3'd4, 5'd0, 5'd0, 5'd0, 3'd2); idle(12);
    curReq = "R7";  issue(1, 3'd5, 5'd13, 5'd0, 5'd0, 3'd1);
                    issue(1, 3'd0, 5'd14, 5'd0, 5'd0, 3'd1);
                    issue(1, 3'd0, 5'd15, 5'd0, 5'd0, 3'd1); idle(11);
    curReq = "R8";  issue(1, 3'd4, 5'd5, 5'd0, 5'd0, 3'd0);
                    issue(1, 3'd0, 5'd1, 5'd5, 5'd5, 3'd0); idle(3);
    curReq = "R9";  issue(1, 3'd2, 5'd7, 5'd0, 5'd0, 3'd0);
                    issue(1, 3'd0, 5'd7, 5'd0, 5'd0, 3'd1);
    for (int k = 0; k < 6; k++) issue(1, 3'd4, 5'd0, 5'd7, 5'd0, 3'd3);
    curReq = "R10"; issue(1, 3'd2, 5'd18, 5'd0, 5'd0, 3'd4);
                    issue(0, 3'd0, 5'd0, 5'd18, 5'd18, 3'd4);
                    issue(1, 3'd4, 5'd0, 5'd2, 5'd18, 3'd5); idle(5);
    curReq = "R12"; issue(1, 3'd6, 5'd8, 5'd0, 5'd0, 3'd2);
                    issue(1, 3'd7, 5'd8, 5'd0, 5'd0, 3'd2); idle(12);
    curReq = "random";
    for (int k = 0; k < 4000; k++)
      issue(1'($urandom_range(0, 3) != 0), 3'($urandom_range(0, 7)),
            5'($urandom_range(0, 31)), 5'($urandom_range(0, 31)),
            5'($urandom_range(0, 31)), 3'($urandom_range(0, 7)));
    idle(12);
    @(negedge clk); #1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule